// File: doc/BRIEF.md
# Indirect Serial Flash Read Engine

This block fetches a run of bytes from a serial flash over a single-data-line SPI link (mode 0) and places them in a word-wide on-chip buffer. The host then reads that buffer out. The host first sets up the command: read opcode, start address, address width, an optional mode byte, a dummy clock count and the total byte count. It then writes a start bit to the control register.

The engine lowers chip select and shifts out the opcode, the address and the mode byte. It runs the dummy clocks, then clocks in the data bytes. Each group of four bytes is packed into one 32-bit word and pushed into a FIFO. The host can watch the word fill level and read the FIFO while the transfer is still running. If the FIFO fills up, the engine parks the serial clock until space appears.

A done flag is raised at completion and is cleared by writing one to it. A cancel bit ends a running transfer cleanly at a byte boundary.

Top module: `qrd_top`

## Requirements
- R1: Writing the control byte with bit 0 set and bit 1 clear starts a transfer when idle. Status bit 2 reads 1 while a transfer runs. Status bit 5 (done) sets when the last data byte is received. Writing 1 to bit 5 clears done, and a start also clears it. A start written while a transfer runs has no effect on that transfer.
- R2: After chip select falls, the engine sends the 8-bit opcode, then the address, each most significant bit first. The address-size field holds the byte count minus one: value 3 sends all 32 address bits, and any other value sends the low 24 bits.
- R3: When mode enable is high, the 8-bit mode value follows the address directly. When it is low, no mode bits are sent.
- R4: After the header, the engine produces exactly as many extra serial clocks as the 5-bit dummy field gives, with MOSI held low.
- R5: Received bytes are taken MSB first. The first byte of each group of four lands in bits 7:0 of the word. The level output counts whole words waiting. A read strobe with level nonzero returns the oldest word on buf_rdata one clock later. The level never exceeds the FIFO depth.
- R6: When the byte count is not a multiple of four, the final word is zero-padded in its unused upper bytes and counts as one word in the level.
- R7: If the FIFO is full, or becomes full on the word being written, at the start of a data byte, the engine holds SCLK low with chip select asserted. It resumes once the host reads a word.
- R8: Writing bit 1 (cancel) during a transfer stops it at the next byte boundary. Chip select is raised, the FIFO is emptied (level 0), in-progress clears and done stays 0.
- R9: The byte-count input sets the number of data bytes, and the transfer uses exactly 8 clocks per byte. A count of zero ends the transfer after the header and dummy clocks, with done set and the FIFO empty.
- R10: When idle, chip select is high and SCLK is low. SCLK stays low whenever chip select is high. Each serial bit takes two clock cycles, and MISO is sampled as SCLK rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data: bit0 start, bit1 cancel, bit5 write-one-to-clear done |
| status | output | 8 | Control readback: bit2 in progress, bit5 done, others 0 |
| cfg_opcode | input | 8 | Read opcode |
| cfg_addr | input | 32 | Flash start address |
| cfg_addr_sz | input | 2 | Address bytes minus one (3 means 4 bytes, else 3 bytes) |
| cfg_mode_en | input | 1 | Send mode byte after address |
| cfg_mode | input | 8 | Mode byte value |
| cfg_dummy | input | 5 | Extra dummy clocks after header |
| cfg_len | input | CNT_W | Total data bytes |
| buf_rd | input | 1 | Buffer read strobe |
| buf_rdata | output | 32 | Buffer read word, valid one clock after buf_rd |
| buf_level | output | LVL_W | Words waiting in the buffer |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
Some rules are checked by assertions on every cycle. Chip select stays high and SCLK stays low outside a transfer. The level never exceeds the depth. Done and in-progress are never set together. A write-one to done clears it. SCLK stays low while the buffer is full. Other behaviour only the bench scenarios can show. These are the exact bits of the header and their order, the count of dummy and data clocks, word packing with zero padding, the byte boundary at which a stall or cancel takes hold, and draining while the transfer runs.

// File: rtl/qrd_pkg.sv
package qrd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HDR   = 2'd1,
    ST_DUMMY = 2'd2,
    ST_DATA  = 2'd3
  } qrd_state_t;

  localparam int unsigned HDR_MAX_BITS = 48;
endpackage

// File: rtl/qrd_fifo.sv
module qrd_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 32,
  parameter int unsigned LVL_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic [LVL_W-1:0] level
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             full, empty, do_wr, do_rd;

  assign full  = (level == LVL_W'(DEPTH));
  assign empty = (level == '0);
  assign do_wr = wr_en && !full && !flush;
  assign do_rd = rd_en && !empty && !flush;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (do_rd) rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_wr) wr_ptr <= bump(wr_ptr);
      if (do_rd) rd_ptr <= bump(rd_ptr);
      case ({do_wr, do_rd})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/qrd_packer.sv
module qrd_packer #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             in_last,
  output logic             out_wr,
  output logic [WIDTH-1:0] out_word
);
  localparam int unsigned LANES = WIDTH / 8;
  localparam int unsigned IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [WIDTH-1:0] acc;
  logic [IDX_W-1:0] idx;
  logic [WIDTH-1:0] lane_word [LANES];

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign lane_word[g] = (idx == IDX_W'(g)) ? (WIDTH'(in_byte) << (8 * g)) : '0;
    end
  endgenerate

  always_comb begin
    out_word = acc;
    for (int k = 0; k < LANES; k++) out_word = out_word | lane_word[k];
  end

  assign out_wr = in_valid && ((idx == IDX_W'(LANES - 1)) || in_last);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      acc <= '0;
      idx <= '0;
    end else if (in_valid) begin
      if (out_wr) begin
        acc <= '0;
        idx <= '0;
      end else begin
        acc <= out_word;
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/qrd_top.sv
module qrd_top
  import qrd_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned LVL_W      = 16,
  parameter int unsigned CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_we,
  input  logic [7:0]       ctrl_wdata,
  output logic [7:0]       status,
  input  logic [7:0]       cfg_opcode,
  input  logic [31:0]      cfg_addr,
  input  logic [1:0]       cfg_addr_sz,
  input  logic             cfg_mode_en,
  input  logic [7:0]       cfg_mode,
  input  logic [4:0]       cfg_dummy,
  input  logic [CNT_W-1:0] cfg_len,
  input  logic             buf_rd,
  output logic [31:0]      buf_rdata,
  output logic [LVL_W-1:0] buf_level,
  output logic             spi_sclk,
  output logic             spi_cs_n,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  localparam int unsigned HW = HDR_MAX_BITS;

  qrd_state_t       state;
  logic [HW-1:0]    tx_sr, hdr_word;
  logic [5:0]       hdr_left, hdr_bits;
  logic [4:0]       dmy_left;
  logic [CNT_W-1:0] bytes_left;
  logic [2:0]       bit_idx;
  logic [7:0]       rx_sr;
  logic             busy, done, cancel_pend, flush;
  logic             pk_valid, pk_last, pk_wr;
  logic [7:0]       pk_byte;
  logic [31:0]      pk_word;
  logic             room_low, start_req;

  assign status    = {2'b00, done, 2'b00, busy, 2'b00};
  assign spi_mosi  = tx_sr[HW-1];
  assign start_req = ctrl_we && ctrl_wdata[0] && !ctrl_wdata[1];
  assign room_low  = (buf_level == LVL_W'(FIFO_DEPTH)) ||
                     ((buf_level == LVL_W'(FIFO_DEPTH - 1)) && pk_wr);

  always_comb begin
    if (cfg_addr_sz == 2'd3) begin
      hdr_word = {cfg_opcode, cfg_addr, cfg_mode_en ? cfg_mode : 8'h00};
      hdr_bits = cfg_mode_en ? 6'd48 : 6'd40;
    end else begin
      hdr_word = {cfg_opcode, cfg_addr[23:0], cfg_mode_en ? cfg_mode : 8'h00, 8'h00};
      hdr_bits = cfg_mode_en ? 6'd40 : 6'd32;
    end
  end

  always_ff @(posedge clk) begin
    flush    <= 1'b0;
    pk_valid <= 1'b0;
    if (rst) begin
      state       <= ST_IDLE;
      tx_sr       <= '0;
      hdr_left    <= '0;
      dmy_left    <= '0;
      bytes_left  <= '0;
      bit_idx     <= '0;
      rx_sr       <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
      cancel_pend <= 1'b0;
      spi_sclk    <= 1'b0;
      spi_cs_n    <= 1'b1;
      pk_byte     <= '0;
      pk_last     <= 1'b0;
    end else begin
      if (ctrl_we && ctrl_wdata[5]) done <= 1'b0;
      if (busy && ctrl_we && ctrl_wdata[1]) cancel_pend <= 1'b1;
      case (state)
        ST_IDLE: if (start_req) begin
          tx_sr       <= hdr_word;
          hdr_left    <= hdr_bits;
          dmy_left    <= cfg_dummy;
          bytes_left  <= cfg_len;
          bit_idx     <= '0;
          busy        <= 1'b1;
          done        <= 1'b0;
          cancel_pend <= 1'b0;
          spi_cs_n    <= 1'b0;
          flush       <= 1'b1;
          state       <= ST_HDR;
        end
        ST_HDR, ST_DUMMY: begin
          if (!spi_sclk) begin
            if (cancel_pend && bit_idx == '0) begin
              state <= ST_IDLE; busy <= 1'b0; spi_cs_n <= 1'b1;
              flush <= 1'b1; cancel_pend <= 1'b0;
            end else spi_sclk <= 1'b1;
          end else begin
            spi_sclk <= 1'b0;
            tx_sr    <= tx_sr << 1;
            bit_idx  <= bit_idx + 1'b1;
            if (state == ST_HDR) hdr_left <= hdr_left - 1'b1;
            else                 dmy_left <= dmy_left - 1'b1;
            if ((state == ST_HDR && hdr_left == 6'd1) ||
                (state == ST_DUMMY && dmy_left == 5'd1)) begin
              bit_idx <= '0;
              if (state == ST_HDR && dmy_left != '0) state <= ST_DUMMY;
              else if (bytes_left != '0)             state <= ST_DATA;
              else begin
                state <= ST_IDLE; busy <= 1'b0; done <= 1'b1; spi_cs_n <= 1'b1;
              end
            end
          end
        end
        ST_DATA: begin
          if (!spi_sclk) begin
            if (cancel_pend && bit_idx == '0) begin
              state <= ST_IDLE; busy <= 1'b0; spi_cs_n <= 1'b1;
              flush <= 1'b1; cancel_pend <= 1'b0;
            end else if (!(bit_idx == '0 && room_low)) begin
              spi_sclk <= 1'b1;
              rx_sr    <= {rx_sr[6:0], spi_miso};
            end
          end else begin
            spi_sclk <= 1'b0;
            bit_idx  <= bit_idx + 1'b1;
            if (bit_idx == 3'd7) begin
              pk_valid   <= 1'b1;
              pk_byte    <= rx_sr;
              pk_last    <= (bytes_left == CNT_W'(1));
              bytes_left <= bytes_left - 1'b1;
              if (bytes_left == CNT_W'(1)) begin
                state <= ST_IDLE; busy <= 1'b0; done <= 1'b1; spi_cs_n <= 1'b1;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  qrd_packer #(.WIDTH(32)) u_pack (
    .clk(clk), .rst(rst), .flush(flush),
    .in_valid(pk_valid), .in_byte(pk_byte), .in_last(pk_last),
    .out_wr(pk_wr), .out_word(pk_word)
  );

  qrd_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(32), .LVL_W(LVL_W)) u_fifo (
    .clk(clk), .rst(rst), .flush(flush),
    .wr_en(pk_wr), .wr_data(pk_word),
    .rd_en(buf_rd), .rd_data(buf_rdata), .level(buf_level)
  );
endmodule

// File: rtl/qrd_checker.sv
module qrd_checker #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LVL_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             ctrl_we,
  input logic [7:0]       ctrl_wdata,
  input logic [7:0]       status,
  input logic [LVL_W-1:0] buf_level,
  input logic             spi_sclk,
  input logic             spi_cs_n
);
  p_idle_cs_r10: assert property (@(posedge clk) disable iff (rst)
    !status[2] |-> spi_cs_n);

  p_sclk_low_r10: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sclk);

  p_level_max_r5: assert property (@(posedge clk) disable iff (rst)
    buf_level <= LVL_W'(DEPTH));

  p_done_idle_r1: assert property (@(posedge clk) disable iff (rst)
    status[5] |-> !status[2]);

  p_w1c_r1: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && ctrl_wdata[5] && !status[2]) |=> !status[5]);

  p_stall_r7: assert property (@(posedge clk) disable iff (rst)
    (buf_level == LVL_W'(DEPTH) && !spi_sclk && !spi_cs_n) |=> !spi_sclk);
endmodule

bind qrd_top qrd_checker #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_qrd_chk (
  .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
  .status(status), .buf_level(buf_level), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n)
);

// File: tb/test_qrd_top.sv
module test_qrd_top;
  localparam int DEPTH = 8;
  localparam int LVL_W = 16;
  localparam int CNT_W = 16;

  logic             clk = 0, rst = 1;
  logic             ctrl_we = 0;
  logic [7:0]       ctrl_wdata = 0;
  logic [7:0]       status;
  logic [7:0]       cfg_opcode = 0, cfg_mode = 0;
  logic [31:0]      cfg_addr = 0;
  logic [1:0]       cfg_addr_sz = 0;
  logic             cfg_mode_en = 0;
  logic [4:0]       cfg_dummy = 0;
  logic [CNT_W-1:0] cfg_len = 0;
  logic             buf_rd = 0;
  logic [31:0]      buf_rdata;
  logic [LVL_W-1:0] buf_level;
  logic             spi_sclk, spi_cs_n, spi_mosi;
  logic             spi_miso = 0;

  always #2.5 clk = ~clk;

  qrd_top #(.FIFO_DEPTH(DEPTH), .LVL_W(LVL_W), .CNT_W(CNT_W)) i_qrd_top (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .status(status),
    .cfg_opcode(cfg_opcode), .cfg_addr(cfg_addr), .cfg_addr_sz(cfg_addr_sz),
    .cfg_mode_en(cfg_mode_en), .cfg_mode(cfg_mode), .cfg_dummy(cfg_dummy),
    .cfg_len(cfg_len), .buf_rd(buf_rd), .buf_rdata(buf_rdata), .buf_level(buf_level),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int errors = 0, checks = 0;
  bit finished = 0;
  int seed = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int b);
    return 8'((b * 37 + seed) ^ 8'h5A);
  endfunction

  // flash model
  int          rise_cnt = 0, pre_bits = 0, hdr_bits = 0, dmy_bad = 0;
  logic [63:0] hdr_cap = 0;

  always @(negedge spi_cs_n) begin
    rise_cnt = 0; hdr_cap = 0; dmy_bad = 0; spi_miso = 0;
  end
  always @(posedge spi_sclk) begin
    if (!spi_cs_n) begin
      if (rise_cnt < hdr_bits) hdr_cap = {hdr_cap[62:0], spi_mosi};
      else if (rise_cnt < pre_bits && spi_mosi) dmy_bad++;
      rise_cnt++;
    end
  end
  always @(negedge spi_sclk) begin
    int k;
    k = rise_cnt - pre_bits;
    if (k >= 0) spi_miso = pat(k / 8)[7 - (k % 8)];
    else        spi_miso = 1'b0;
  end

  // scoreboard
  logic [31:0] exp_q[$];
  bit drain_en = 0, rd_pend = 0;

  initial begin
    forever begin
      @(negedge clk);
      if (rd_pend) begin
        if (exp_q.size() == 0) chk(0, "R5 unexpected word", buf_rdata, 0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(buf_rdata == e, "R5/R6 word data", buf_rdata, e);
        end
      end
      rd_pend = 0;
      buf_rd  = 0;
      if (drain_en && buf_level != 0) begin
        buf_rd  = 1;
        rd_pend = 1;
      end
    end
  end

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk); ctrl_we = 1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 0; ctrl_wdata = 0;
  endtask

  task automatic setup(input logic [7:0] op, input logic [31:0] ad, input logic [1:0] asz,
                       input bit men, input logic [7:0] md, input int dmy, input int len,
                       output logic [63:0] exp_hdr);
    int nw;
    cfg_opcode = op; cfg_addr = ad; cfg_addr_sz = asz; cfg_mode_en = men;
    cfg_mode = md; cfg_dummy = 5'(dmy); cfg_len = CNT_W'(len);
    exp_hdr = 64'(op);
    if (asz == 2'd3) exp_hdr = (exp_hdr << 32) | 64'(ad);
    else             exp_hdr = (exp_hdr << 24) | 64'(ad[23:0]);
    if (men) exp_hdr = (exp_hdr << 8) | 64'(md);
    hdr_bits = 8 + ((asz == 2'd3) ? 32 : 24) + (men ? 8 : 0);
    pre_bits = hdr_bits + dmy;
    nw = (len + 3) / 4;
    for (int w = 0; w < nw; w++) begin
      logic [31:0] word;
      word = 0;
      for (int b = 0; b < 4; b++)
        if (w * 4 + b < len) word = word | (32'(pat(w * 4 + b)) << (8 * b));
      exp_q.push_back(word);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && status[2]; i++) @(negedge clk);
  endtask

  task automatic wait_drained();
    for (int i = 0; i < 2000 && (exp_q.size() != 0 || buf_level != 0); i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] eh;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(status == 8'h00, "R1 reset status", status, 0);
    chk(buf_level == 0, "R5 reset level", buf_level, 0);
    chk(spi_cs_n == 1 && spi_sclk == 0, "R10 idle pins", {spi_cs_n, spi_sclk}, 2'b10);

    // A: 3-byte addr, mode byte, 8 dummy, 10 bytes, drained live, redundant start
    seed = 3; drain_en = 1;
    setup(8'h0B, 32'hAB123456, 2'd2, 1, 8'hA5, 8, 10, eh);
    wr_ctrl(8'h01);
    @(negedge clk);
    chk(status[2] == 1 && spi_cs_n == 0, "R1 in progress", status, 8'h04);
    repeat (40) @(negedge clk);
    wr_ctrl(8'h01);
    wait_idle();
    chk(status == 8'h20, "R1 done set", status, 8'h20);
    chk(hdr_cap == eh, "R2/R3 header bits", hdr_cap, eh);
    chk(dmy_bad == 0, "R4 dummy mosi low", dmy_bad, 0);
    chk(rise_cnt == pre_bits + 80, "R9/R4 clock count", rise_cnt, pre_bits + 80);
    wait_drained();
    chk(exp_q.size() == 0, "R5 all words read", exp_q.size(), 0);
    wr_ctrl(8'h00);
    chk(status[5] == 1, "R1 write zero keeps done", status, 8'h20);
    wr_ctrl(8'h20);
    chk(status[5] == 0, "R1 w1c done", status, 0);

    // B: 4-byte addr, no mode, no dummy, 6 bytes (partial word), undrained
    seed = 91; drain_en = 0;
    setup(8'h13, 32'hC0DE5A17, 2'd3, 0, 8'hFF, 0, 6, eh);
    wr_ctrl(8'h01);
    wait_idle();
    repeat (4) @(negedge clk);
    chk(hdr_cap == eh, "R2 4-byte address", hdr_cap, eh);
    chk(rise_cnt == 40 + 48, "R3/R9 no mode clocks", rise_cnt, 88);
    chk(buf_level == 2, "R6 padded word counted", buf_level, 2);
    drain_en = 1; wait_drained();
    chk(buf_level == 0, "R5 level after drain", buf_level, 0);

    // C: stall on full buffer, odd dummy count
    seed = 200; drain_en = 0;
    setup(8'h6B, 32'h00FEDCBA, 2'd3, 1, 8'h00, 3, 40, eh);
    wr_ctrl(8'h21);
    for (int i = 0; i < 5000 && buf_level != DEPTH; i++) @(negedge clk);
    repeat (20) @(negedge clk);
    begin
      int snap;
      snap = rise_cnt;
      repeat (200) @(negedge clk);
      chk(rise_cnt == snap && spi_sclk == 0, "R7 sclk parked", rise_cnt, snap);
      chk(rise_cnt - pre_bits == 8 * 4 * DEPTH, "R7 stall boundary", rise_cnt - pre_bits, 8 * 4 * DEPTH);
      chk(buf_level == DEPTH && status[2] && !spi_cs_n, "R7 full and busy", buf_level, DEPTH);
    end
    drain_en = 1;
    wait_idle();
    wait_drained();
    chk(exp_q.size() == 0 && status == 8'h20, "R7 resume to done", status, 8'h20);

    // D: cancel mid-byte
    seed = 17; drain_en = 0;
    setup(8'h0B, 32'h00000100, 2'd2, 0, 8'h00, 8, 64, eh);
    exp_q.delete();
    wr_ctrl(8'h01);
    for (int i = 0; i < 5000 && rise_cnt < pre_bits + 13; i++) @(negedge clk);
    wr_ctrl(8'h02);
    for (int i = 0; i < 100 && status[2]; i++) @(negedge clk);
    @(negedge clk);
    chk(status == 8'h00, "R8 cancel status", status, 0);
    chk(spi_cs_n == 1 && buf_level == 0, "R8 cs high, flushed", buf_level, 0);
    chk((rise_cnt - pre_bits) % 8 == 0, "R8 byte boundary", rise_cnt - pre_bits, 16);
    begin
      int snap;
      snap = rise_cnt;
      repeat (50) @(negedge clk);
      chk(rise_cnt == snap, "R8 no clocks after cancel", rise_cnt, snap);
    end

    // E: zero length
    seed = 5; drain_en = 1;
    setup(8'h03, 32'h00001234, 2'd2, 0, 8'h00, 0, 0, eh);
    wr_ctrl(8'h01);
    wait_idle();
    repeat (4) @(negedge clk);
    chk(status == 8'h20 && buf_level == 0, "R9 zero length", status, 8'h20);
    chk(rise_cnt == 32 && hdr_cap == eh, "R9/R2 header only", rise_cnt, 32);

    drain_en = 0;
    repeat (5) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule